// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands in four register-separated segments. Each operand is a sign-magnitude fraction (a sign bit over a 15-bit magnitude whose top bit carries weight one half) with an 8-bit two's-complement exponent. The value of an operand is (-1)^sign × magnitude × 2^exponent. The first segment compares the exponents. The second shifts the mantissa of the operand with the smaller exponent right to align it. The third adds or subtracts the magnitudes. The fourth normalizes the result and adjusts the exponent.

Operands enter on a valid/ready stream. The result leaves on a second valid/ready stream. Back-pressure follows these rules. The whole pipe moves forward on any cycle in which the output register is empty or the consumer has `out_ready` high. `in_ready` shows that condition. An input is taken on a rising edge where both `in_valid` and `in_ready` are high. While `out_valid` is high and `out_ready` is low, the output holds steady and no input is taken. If `out_ready` is held high, one result can leave every cycle.

Rounding, special values and exception traps are not provided. Exponent overflow and underflow are only flagged.

Top module: `fpa_pipe_add`

## Requirements
- R1: A nonzero result is normalized: out_man[14] is 1 whenever out_man[14:0] is nonzero, and out_man[15] is the sign (1 = negative).
- R2: When the magnitude sum carries past bit 14, the result magnitude is the sum shifted right one place and the exponent is one higher than the larger input exponent.
- R3: The operand with the smaller exponent has its magnitude shifted right by the exponent difference, with shifted-out bits dropped. If the exponents are equal, A counts as the larger.
- R4: A difference of 15 or more aligns the smaller operand to zero, so the result equals the operand with the larger exponent.
- R5: in_sub = 1 inverts the sign of B. When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger magnitude.
- R6: After a subtraction, leading zeros in the magnitude are removed by a left shift, and the exponent is decreased by the same count.
- R7: A zero result gives out_man = 16'h0000 and out_exp = 8'h80 (the most negative exponent), with both flags low.
- R8: When the adjusted exponent exceeds +127, out_ovf is 1 and out_exp keeps the low 8 bits of the true exponent.
- R9: When the adjusted exponent falls below -128, out_unf is 1 and out_exp keeps the low 8 bits of the true exponent.
- R10: If out_ready is held high, a result appears with out_valid on the fourth rising edge after its input is taken, and inputs are taken on back-to-back cycles.
- R11: While out_valid is high and out_ready is low, in_ready is low and out_man, out_exp and the flags hold steady.
- R12: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pipe can take an operand pair this cycle |
| in_sub | input | 1 | 1 = compute A - B, 0 = A + B |
| in_a_man | input | 16 | Operand A sign (bit 15) and magnitude |
| in_a_exp | input | 8 | Operand A exponent, two's complement |
| in_b_man | input | 16 | Operand B sign (bit 15) and magnitude |
| in_b_exp | input | 8 | Operand B exponent, two's complement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_man | output | 16 | Result sign (bit 15) and normalized magnitude |
| out_exp | output | 8 | Result exponent, two's complement |
| out_ovf | output | 1 | Result exponent overflowed |
| out_unf | output | 1 | Result exponent underflowed |

## Verification
Directed operand pairs cover each path separately:
- equal exponents with a carry out;
- a small exponent gap, which tests the shift amount;
- a gap wider than the mantissa;
- a subtraction that leaves leading zeros;
- a subtraction whose B magnitude is larger, which tests the sign choice;
- exact cancellation to zero;
- exponents at both ends of the range, which drive the overflow and underflow flags.

Long runs of random normalized operands then use mixed signs, exponents and operations while the consumer withholds ready at random. This checks that results stay in order and are not lost or duplicated under stalls. A single isolated operand with ready held high measures the latency. A back-to-back burst confirms that no input waits.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic {
    SGN_POS = 1'b0,
    SGN_NEG = 1'b1
  } sgn_e;

  localparam int unsigned FPA_SEGMENTS = 4;
endpackage

// File: rtl/fpa_exp_cmp.sv
module fpa_exp_cmp #(
  parameter int EXP_W = 8,
  parameter int MAG_W = 15,
  parameter int SH_W  = 4
) (
  input  logic [EXP_W-1:0] ea,
  input  logic [EXP_W-1:0] eb,
  output logic             a_big,
  output logic [EXP_W-1:0] max_exp,
  output logic [SH_W-1:0]  shamt
);
  localparam int DW = EXP_W + 1;

  logic signed [DW-1:0] diff;
  logic        [DW-1:0] absd;

  always_comb begin
    diff    = $signed({ea[EXP_W-1], ea}) - $signed({eb[EXP_W-1], eb});
    a_big   = !diff[DW-1];
    absd    = a_big ? diff : -diff;
    max_exp = a_big ? ea : eb;
    if (absd >= DW'(MAG_W)) shamt = SH_W'(MAG_W);
    else                    shamt = absd[SH_W-1:0];
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int MAG_W = 15,
  parameter int SH_W  = 4
) (
  input  logic [MAG_W-1:0] mag_in,
  input  logic [SH_W-1:0]  shamt,
  output logic [MAG_W-1:0] mag_out
);
  always_comb begin
    if (shamt >= SH_W'(MAG_W)) mag_out = '0;
    else                       mag_out = mag_in >> shamt;
  end
endmodule

// File: rtl/fpa_mag_addsub.sv
module fpa_mag_addsub #(
  parameter int MAG_W = 15
) (
  input  logic [MAG_W-1:0] big_mag,
  input  logic             big_sgn,
  input  logic [MAG_W-1:0] sml_mag,
  input  logic             sml_sgn,
  output logic [MAG_W:0]   sum,
  output logic             sum_sgn
);
  always_comb begin
    if (big_sgn == sml_sgn) begin
      sum     = {1'b0, big_mag} + {1'b0, sml_mag};
      sum_sgn = big_sgn;
    end else if (big_mag >= sml_mag) begin
      sum     = {1'b0, big_mag} - {1'b0, sml_mag};
      sum_sgn = big_sgn;
    end else begin
      sum     = {1'b0, sml_mag} - {1'b0, big_mag};
      sum_sgn = sml_sgn;
    end
  end
endmodule

// File: rtl/fpa_normalize.sv
module fpa_normalize import fpa_pkg::*; #(
  parameter int MAG_W = 15,
  parameter int EXP_W = 8
) (
  input  logic [MAG_W:0]   sum,
  input  logic             sum_sgn,
  input  logic [EXP_W-1:0] exp_in,
  output logic [MAG_W:0]   man_out,
  output logic [EXP_W-1:0] exp_out,
  output logic             ovf,
  output logic             unf
);
  localparam int LZ_W = $clog2(MAG_W + 1);
  localparam int XW   = EXP_W + 2;
  localparam logic signed [XW-1:0] EMAX = XW'((2 ** (EXP_W - 1)) - 1);
  localparam logic signed [XW-1:0] EMIN = -XW'(2 ** (EXP_W - 1));

  logic [LZ_W-1:0]       lz;
  logic [MAG_W-1:0]      hit;
  logic signed [XW-1:0]  e_wide;
  logic [MAG_W-1:0]      mag_n;

  // one-hot marks of each set bit, leading-zero count from the highest
  for (genvar g = 0; g < MAG_W; g++) begin : g_hit
    assign hit[g] = sum[g];
  end

  always_comb begin
    lz = '0;
    for (int i = 0; i < MAG_W; i++) begin
      if (hit[i]) lz = LZ_W'(MAG_W - 1 - i);
    end
  end

  always_comb begin
    e_wide = $signed({{(XW-EXP_W){exp_in[EXP_W-1]}}, exp_in});
    mag_n  = '0;
    if (sum[MAG_W]) begin
      mag_n  = sum[MAG_W:1];
      e_wide = e_wide + XW'(1);
    end else if (sum != '0) begin
      mag_n  = sum[MAG_W-1:0] << lz;
      e_wide = e_wide - $signed({{(XW-LZ_W){1'b0}}, lz});
    end
    if (sum == '0) begin
      man_out = {SGN_POS, {MAG_W{1'b0}}};
      exp_out = EMIN[EXP_W-1:0];
      ovf     = 1'b0;
      unf     = 1'b0;
    end else begin
      man_out = {sum_sgn, mag_n};
      exp_out = e_wide[EXP_W-1:0];
      ovf     = e_wide > EMAX;
      unf     = e_wide < EMIN;
    end
  end
endmodule

// File: rtl/fpa_pipe_add.sv
module fpa_pipe_add #(
  parameter int MAG_W = 15,
  parameter int EXP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_sub,
  input  logic [MAG_W:0]     in_a_man,
  input  logic [EXP_W-1:0]   in_a_exp,
  input  logic [MAG_W:0]     in_b_man,
  input  logic [EXP_W-1:0]   in_b_exp,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [MAG_W:0]     out_man,
  output logic [EXP_W-1:0]   out_exp,
  output logic               out_ovf,
  output logic               out_unf
);
  localparam int SH_W = $clog2(MAG_W + 1);

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // segment 1: exponent compare and operand swap
  logic             c_a_big;
  logic [EXP_W-1:0] c_max;
  logic [SH_W-1:0]  c_sh;
  logic             b_sgn_eff;

  fpa_exp_cmp #(.EXP_W(EXP_W), .MAG_W(MAG_W), .SH_W(SH_W)) u_cmp (
    .ea(in_a_exp), .eb(in_b_exp), .a_big(c_a_big), .max_exp(c_max), .shamt(c_sh)
  );
  assign b_sgn_eff = in_b_man[MAG_W] ^ in_sub;

  logic             s1_v, s1_bs, s1_ss;
  logic [MAG_W-1:0] s1_bm, s1_sm;
  logic [EXP_W-1:0] s1_e;
  logic [SH_W-1:0]  s1_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_bs <= 1'b0; s1_ss <= 1'b0;
      s1_bm <= '0; s1_sm <= '0; s1_e <= '0; s1_sh <= '0;
    end else if (adv) begin
      s1_v  <= in_valid;
      s1_e  <= c_max;
      s1_sh <= c_sh;
      if (c_a_big) begin
        s1_bm <= in_a_man[MAG_W-1:0]; s1_bs <= in_a_man[MAG_W];
        s1_sm <= in_b_man[MAG_W-1:0]; s1_ss <= b_sgn_eff;
      end else begin
        s1_bm <= in_b_man[MAG_W-1:0]; s1_bs <= b_sgn_eff;
        s1_sm <= in_a_man[MAG_W-1:0]; s1_ss <= in_a_man[MAG_W];
      end
    end
  end

  // segment 2: alignment shift
  logic [MAG_W-1:0] al_mag;
  fpa_align #(.MAG_W(MAG_W), .SH_W(SH_W)) u_align (
    .mag_in(s1_sm), .shamt(s1_sh), .mag_out(al_mag)
  );

  logic             s2_v, s2_bs, s2_ss;
  logic [MAG_W-1:0] s2_bm, s2_sm;
  logic [EXP_W-1:0] s2_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_bs <= 1'b0; s2_ss <= 1'b0;
      s2_bm <= '0; s2_sm <= '0; s2_e <= '0;
    end else if (adv) begin
      s2_v <= s1_v; s2_bs <= s1_bs; s2_ss <= s1_ss;
      s2_bm <= s1_bm; s2_sm <= al_mag; s2_e <= s1_e;
    end
  end

  // segment 3: magnitude add or subtract
  logic [MAG_W:0] as_sum;
  logic           as_sgn;
  fpa_mag_addsub #(.MAG_W(MAG_W)) u_addsub (
    .big_mag(s2_bm), .big_sgn(s2_bs), .sml_mag(s2_sm), .sml_sgn(s2_ss),
    .sum(as_sum), .sum_sgn(as_sgn)
  );

  logic             s3_v, s3_sg;
  logic [MAG_W:0]   s3_sum;
  logic [EXP_W-1:0] s3_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_v <= 1'b0; s3_sg <= 1'b0; s3_sum <= '0; s3_e <= '0;
    end else if (adv) begin
      s3_v <= s2_v; s3_sg <= as_sgn; s3_sum <= as_sum; s3_e <= s2_e;
    end
  end

  // segment 4: normalize and adjust exponent
  logic [MAG_W:0]   n_man;
  logic [EXP_W-1:0] n_exp;
  logic             n_ovf, n_unf;
  fpa_normalize #(.MAG_W(MAG_W), .EXP_W(EXP_W)) u_norm (
    .sum(s3_sum), .sum_sgn(s3_sg), .exp_in(s3_e),
    .man_out(n_man), .exp_out(n_exp), .ovf(n_ovf), .unf(n_unf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_man <= '0; out_exp <= '0;
      out_ovf <= 1'b0; out_unf <= 1'b0;
    end else if (adv) begin
      out_valid <= s3_v; out_man <= n_man; out_exp <= n_exp;
      out_ovf <= n_ovf; out_unf <= n_unf;
    end
  end
endmodule

// File: rtl/fpa_pipe_add_chk.sv
module fpa_pipe_add_chk #(
  parameter int MAG_W = 15,
  parameter int EXP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [MAG_W:0]   out_man,
  input logic [EXP_W-1:0] out_exp,
  input logic             out_ovf,
  input logic             out_unf
);
  AST_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_man[MAG_W-1:0] != '0) |-> out_man[MAG_W-1]); // R1

  AST_ZERO_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_man[MAG_W-1:0] == '0) |->
      (!out_man[MAG_W] && out_exp == {1'b1, {(EXP_W-1){1'b0}}} && !out_ovf && !out_unf)); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_ovf && out_unf)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_man) && $stable(out_exp) && $stable(out_ovf) && $stable(out_unf))); // R11

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R11

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R12
endmodule

bind fpa_pipe_add fpa_pipe_add_chk #(.MAG_W(MAG_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_man(out_man), .out_exp(out_exp),
  .out_ovf(out_ovf), .out_unf(out_unf)
);

// File: tb/fpa_pipe_add_test.sv
`timescale 1ns/1ps
module fpa_pipe_add_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sub = 1'b0, out_ready = 1'b1;
  logic [15:0] in_a_man = '0, in_b_man = '0;
  logic [7:0]  in_a_exp = '0, in_b_exp = '0;
  logic in_ready, out_valid, out_ovf, out_unf;
  logic [15:0] out_man;
  logic [7:0]  out_exp;

  int checks = 0, errors = 0, waits = 0;
  bit bp_mode = 1'b0, done = 1'b0;

  typedef struct { logic [15:0] man; logic [7:0] ex; logic ovf; logic unf; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  fpa_pipe_add uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sub(in_sub),
    .in_a_man(in_a_man), .in_a_exp(in_a_exp), .in_b_man(in_b_man), .in_b_exp(in_b_exp),
    .out_valid(out_valid), .out_ready(out_ready), .out_man(out_man), .out_exp(out_exp),
    .out_ovf(out_ovf), .out_unf(out_unf)
  );

  task automatic chk(bit ok, string tag, string got, string want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %s expected %s", tag, got, want);
    end
  endtask

  function automatic exp_t model(logic [15:0] am, logic [7:0] ae, logic [15:0] bm,
                                 logic [7:0] be, logic sub, string tag);
    exp_t r;
    int ea, eb, d, e, bmag, smag, sum;
    logic bs, ss, rs;
    ea = int'($signed(ae)); eb = int'($signed(be));
    if (ea >= eb) begin
      bmag = int'(am[14:0]); bs = am[15]; smag = int'(bm[14:0]); ss = bm[15] ^ sub;
      e = ea; d = ea - eb;
    end else begin
      bmag = int'(bm[14:0]); bs = bm[15] ^ sub; smag = int'(am[14:0]); ss = am[15];
      e = eb; d = eb - ea;
    end
    if (d >= 15) smag = 0; else smag = smag >> d;
    if (bs == ss) begin sum = bmag + smag; rs = bs; end
    else if (bmag >= smag) begin sum = bmag - smag; rs = bs; end
    else begin sum = smag - bmag; rs = ss; end
    r.tag = tag;
    if (sum == 0) begin
      r.man = 16'h0000; r.ex = 8'h80; r.ovf = 1'b0; r.unf = 1'b0;
    end else begin
      while (sum >= 32768) begin sum = sum >> 1; e++; end
      while (sum < 16384) begin sum = sum << 1; e--; end
      r.man = {rs, 15'(sum)}; r.ex = 8'(e);
      r.ovf = e > 127; r.unf = e < -128;
    end
    return r;
  endfunction

  task automatic send(logic [15:0] am, logic [7:0] ae, logic [15:0] bm, logic [7:0] be,
                      logic sub, string tag);
    @(negedge clk);
    in_a_man = am; in_a_exp = ae; in_b_man = bm; in_b_exp = be; in_sub = sub; in_valid = 1'b1;
    #2;
    while (!in_ready) begin waits++; @(negedge clk); #2; end
    q.push_back(model(am, ae, bm, be, sub, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  logic [15:0] h_man; logic [7:0] h_exp; logic h_ovf, h_unf; bit h_act = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (h_act && out_valid)
        chk(out_man == h_man && out_exp == h_exp && out_ovf == h_ovf && out_unf == h_unf,
            "R11 hold", $sformatf("%h/%h", out_man, out_exp), $sformatf("%h/%h", h_man, h_exp));
      out_ready = bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
      #1;
      h_act = rst_n && out_valid && !out_ready;
      h_man = out_man; h_exp = out_exp; h_ovf = out_ovf; h_unf = out_unf;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) chk(1'b0, "R10 extra result", $sformatf("%h", out_man), "none");
        else begin
          exp_t x;
          x = q.pop_front();
          chk(out_man == x.man && out_exp == x.ex && out_ovf == x.ovf && out_unf == x.unf, x.tag,
              $sformatf("man=%h exp=%h ovf=%b unf=%b", out_man, out_exp, out_ovf, out_unf),
              $sformatf("man=%h exp=%h ovf=%b unf=%b", x.man, x.ex, x.ovf, x.unf));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", "timeout", "finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && in_ready, "R12 reset", $sformatf("v=%b r=%b", out_valid, in_ready), "v=0 r=1");
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R12 after reset", $sformatf("v=%b r=%b", out_valid, in_ready), "v=0 r=1");

    // directed cases
    send(16'h6000, 8'd3, 16'h6000, 8'd3, 1'b0, "R2 carry renorm");
    send(16'h7999, 8'd3, 16'h5400, 8'd2, 1'b0, "R2 R3 carry after align");
    send(16'h4000, 8'd5, 16'h4000, 8'd3, 1'b0, "R3 align by two");
    send(16'h4000, 8'hFE, 16'h4001, 8'hFB, 1'b0, "R3 negative exponents");
    send(16'h4000, 8'd0, 16'h7FFF, 8'd20, 1'b0, "R4 wide gap");
    send(16'h7FFF, 8'd15, 16'h7FFF, 8'd0, 1'b0, "R4 gap equals width");
    send(16'h6000, 8'd2, 16'h5000, 8'd2, 1'b1, "R5 R6 subtract lz");
    send(16'h4000, 8'd1, 16'h6000, 8'd1, 1'b1, "R5 sign of larger");
    send(16'hC000, 8'd4, 16'h4000, 8'd4, 1'b1, "R5 neg minus pos");
    send(16'h4001, 8'd0, 16'hC000, 8'd0, 1'b0, "R6 deep cancel");
    send(16'h5555, 8'd7, 16'h5555, 8'd7, 1'b1, "R7 exact zero");
    send(16'h6000, 8'd127, 16'h6000, 8'd127, 1'b0, "R8 overflow");
    send(16'h6000, 8'h80, 16'h5000, 8'h80, 1'b1, "R9 underflow");
    send(16'h4000, 8'h80, 16'h4000, 8'h80, 1'b0, "R1 bottom exponent ok");
    drain();

    // latency of an isolated item
    begin
      int n = 0;
      send(16'h4800, 8'd1, 16'h4800, 8'd1, 1'b0, "R10 latency item");
      idle();
      n = 1;
      #1;
      while (!out_valid && n < 10) begin @(negedge clk); n++; #1; end
      chk(n == 4, "R10 latency", $sformatf("%0d", n), "4");
    end
    drain();

    // throughput burst
    waits = 0;
    for (int i = 0; i < 8; i++)
      send({1'b0, 1'b1, 14'(i * 977)}, 8'(i), 16'h4100, 8'd2, 1'(i % 2), "R10 burst");
    chk(waits == 0, "R10 back-to-back", $sformatf("%0d waits", waits), "0 waits");
    drain();

    // random traffic under back-pressure
    bp_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b;
      a = {1'($urandom_range(0, 1)), 1'b1, 14'($urandom)};
      b = {1'($urandom_range(0, 1)), 1'b1, 14'($urandom)};
      if (i % 37 == 0) b = {~a[15], a[14:0]};
      send(a, 8'($signed($urandom_range(0, 40)) - 20), b,
           8'($signed($urandom_range(0, 40)) - 20), 1'($urandom_range(0, 1)), "R1 R11 random");
    end
    idle();
    bp_mode = 1'b0;
    drain();
    chk(q.size() == 0, "R11 all delivered", $sformatf("%0d left", q.size()), "0 left");
    finish_run();
  end
endmodule